// File: doc/BRIEF.md
# Auxiliary Video Information Packet Scheduler

This block sits between a register port and a video-link packet transmitter. Software fills four 32-bit content words that describe the picture being sent. It then sets a self-clearing update bit in the control register. At the next frame start the block copies those words into a shadow set that feeds the transmitter. A packet therefore always carries words that were staged together. Content writes made without an update command never reach the link.

At each frame start the block decides whether to send. It sends only when sending is enabled. The rate setting chooses one packet per frame or one packet on every second frame. When it sends, it raises a request and presents the shadow words one at a time, in order from word 0 to word 3. It advances one word for each done pulse from the transmitter. Encoding, checksums and serialization belong to the transmitter.

Top module: `avi_pkt_sched`

## Requirements
- R1: After reset, all content words, the shadow words and the control register read 0, and `send_req` is low.
- R2: Addresses 0 to 3 hold content words 0 to 3, and each one reads back the last value written to it. Address 4 is the control register. On a read its bits [2:0] show {update pending, every-other-frame, enable} and its upper bits read 0. Addresses 5 to 7 read 0, and writes to them change nothing.
- R3: A frame start while the enable bit (control bit 0) is 0 raises no request.
- R4: When enable is 1 and the rate bit (control bit 1) is 0, every frame start that finds the transmitter idle raises `send_req` in the next cycle, with `send_idx` at 0.
- R5: When enable and the rate bit are both 1, an alternation flag decides each send. The flag is held at 0 while either bit is 0. A frame start sends only when the flag is 0, and the flag inverts at every such frame start. This is true even while a packet is still being sent.
- R6: Writing 1 to control bit 2 sets the update-pending bit, and a read shows it as 1. The first frame start that finds the transmitter idle copies the four content words into the shadow words and clears the bit. Writing 0 to bit 2 does not clear it.
- R7: The shadow words change only through an update copy. A content write alone never changes what `send_word` presents.
- R8: `send_req` stays high until the transmitter pulses `send_done`. `send_idx` steps 0, 1, 2, 3, advancing by one per done, and `send_word` shows shadow word `send_idx`. A done on word 3 drops `send_req`.
- R9: A frame start while `send_req` is high does not restart the packet, does not copy the shadow words, and leaves the update-pending bit set.
- R10: A `send_done` while `send_req` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Register address for writes and reads |
| reg_wdata | input | WORD_W (32) | Register write data |
| reg_rdata | output | WORD_W (32) | Read data for `reg_addr`, combinational |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| send_req | output | 1 | Packet send request to the transmitter |
| send_idx | output | 2 | Index of the word being presented |
| send_word | output | WORD_W (32) | Shadow word at `send_idx` |
| send_done | input | 1 | Transmitter accepted the presented word |

## Verification
The bench builds the block with its default parameters: 32-bit words, four content words and a 3-bit address. With those defaults the bench reaches every address, including the three unused ones. It also reaches the last word index, where a done ends the packet. Frame starts are kept rare and done pulses frequent. Random stimulus therefore covers frames that land in the middle of a packet, update requests that wait through a busy frame, and rate changes that reset the alternation flag.

// File: rtl/avi_sched_pkg.sv
package avi_sched_pkg;

    // Control register bit positions (software-visible)
    localparam int unsigned EN_BIT   = 0;
    localparam int unsigned RATE_BIT = 1;
    localparam int unsigned UPD_BIT  = 2;

    typedef struct packed {
        logic upd_pend;
        logic every_other;
        logic send_en;
    } avi_ctrl_t;

endpackage

// File: rtl/avi_ctrl_regs.sv
module avi_ctrl_regs
    import avi_sched_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_WORDS = 4,
    parameter int unsigned ADDR_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [WORD_W-1:0]             wdata,
    output logic [WORD_W-1:0]             rdata,
    input  logic                          copy_ack,
    output logic [NUM_WORDS*WORD_W-1:0]   words_flat,
    output avi_ctrl_t                     ctrl
);
    localparam int unsigned IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int unsigned CTRL_ADDR = NUM_WORDS;

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] words;
        avi_ctrl_t                        ctrl;
    } regs_t;

    regs_t r_d, r_q;
    logic  ctrl_wr;
    logic  upd_req;

    always_comb begin
        r_d     = r_q;
        ctrl_wr = wr_en && (addr == ADDR_W'(CTRL_ADDR));
        upd_req = ctrl_wr && wdata[UPD_BIT];
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (wr_en && (addr == ADDR_W'(i))) begin
                r_d.words[i] = wdata;
            end
        end
        if (ctrl_wr) begin
            r_d.ctrl.send_en     = wdata[EN_BIT];
            r_d.ctrl.every_other = wdata[RATE_BIT];
        end
        r_d.ctrl.upd_pend = (r_q.ctrl.upd_pend && !copy_ack) || upd_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr < ADDR_W'(NUM_WORDS)) begin
            rdata = r_q.words[addr[IDX_W-1:0]];
        end else if (addr == ADDR_W'(CTRL_ADDR)) begin
            rdata[EN_BIT]   = r_q.ctrl.send_en;
            rdata[RATE_BIT] = r_q.ctrl.every_other;
            rdata[UPD_BIT]  = r_q.ctrl.upd_pend;
        end
    end

    assign words_flat = r_q.words;
    assign ctrl       = r_q.ctrl;

    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ctrl.upd_pend && !copy_ack |=> r_q.ctrl.upd_pend);

    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_ack && !(wr_en && (addr == ADDR_W'(CTRL_ADDR)) && wdata[UPD_BIT])
        |=> !r_q.ctrl.upd_pend);

endmodule

// File: rtl/avi_rate_gate.sv
module avi_rate_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic send_en,
    input  logic every_other,
    input  logic busy,
    output logic fire
);
    logic tog_d, tog_q;

    always_comb begin
        tog_d = tog_q;
        if (!send_en || !every_other) begin
            tog_d = 1'b0;
        end else if (frame_start) begin
            tog_d = ~tog_q;
        end
        fire = frame_start && send_en && (!every_other || !tog_q) && !busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else begin
            tog_q <= tog_d;
        end
    end

    // R5
    alt_after_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && every_other |=> tog_q);

    // R5
    alt_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && send_en && every_other && tog_q |-> !fire);

endmodule

// File: rtl/avi_pkt_xmit.sv
module avi_pkt_xmit #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_WORDS = 4,
    localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_start,
    input  logic                        upd_pend,
    input  logic [NUM_WORDS*WORD_W-1:0] words_flat,
    input  logic                        fire,
    input  logic                        send_done,
    output logic                        copy_take,
    output logic                        busy,
    output logic                        send_req,
    output logic [IDX_W-1:0]            send_idx,
    output logic [WORD_W-1:0]           send_word
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] shadow;
        logic                             req;
        logic [IDX_W-1:0]                 idx;
    } xs_t;

    xs_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        copy_take = frame_start && upd_pend && !s_q.req;
        if (copy_take) begin
            s_d.shadow = words_flat;
        end
        if (fire) begin
            s_d.req = 1'b1;
            s_d.idx = '0;
        end else if (s_q.req && send_done) begin
            if (s_q.idx == LAST_IDX) begin
                s_d.req = 1'b0;
                s_d.idx = '0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.req;
    assign send_req  = s_q.req;
    assign send_idx  = s_q.idx;
    assign send_word = s_q.shadow[s_q.idx];

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.req && !send_done |=> s_q.req && $stable(s_q.idx));

    // R8
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.req && send_done && (s_q.idx != LAST_IDX)
        |=> s_q.req && (s_q.idx == $past(s_q.idx) + 1'b1));

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(s_q.shadow));

    // R9
    busy_no_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.req && frame_start |=> $stable(s_q.shadow));

    // R10
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.req && !fire |=> !s_q.req);

endmodule

// File: rtl/avi_pkt_sched.sv
module avi_pkt_sched
    import avi_sched_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_WORDS = 4,
    parameter int unsigned ADDR_W    = 3,
    localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              frame_start,
    output logic              send_req,
    output logic [IDX_W-1:0]  send_idx,
    output logic [WORD_W-1:0] send_word,
    input  logic              send_done
);
    logic [NUM_WORDS*WORD_W-1:0] words_flat;
    avi_ctrl_t                   ctrl;
    logic                        copy_take;
    logic                        busy;
    logic                        fire;

    avi_ctrl_regs #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .copy_ack   (copy_take),
        .words_flat (words_flat),
        .ctrl       (ctrl)
    );

    avi_rate_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .send_en     (ctrl.send_en),
        .every_other (ctrl.every_other),
        .busy        (busy),
        .fire        (fire)
    );

    avi_pkt_xmit #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_xmit (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .upd_pend    (ctrl.upd_pend),
        .words_flat  (words_flat),
        .fire        (fire),
        .send_done   (send_done),
        .copy_take   (copy_take),
        .busy        (busy),
        .send_req    (send_req),
        .send_idx    (send_idx),
        .send_word   (send_word)
    );

    // R3
    off_no_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && !ctrl.send_en && !send_req |=> !send_req);

    // R4
    every_frame_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && ctrl.send_en && !ctrl.every_other && !send_req
        |=> send_req && (send_idx == '0));

endmodule

// File: tb/avi_pkt_sched_tb.sv
module avi_pkt_sched_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_start = 1'b0;
    logic        send_req;
    logic [1:0]  send_idx;
    logic [31:0] send_word;
    logic        send_done = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    logic [31:0] m_cont [4];
    logic [31:0] m_shad [4];
    logic        m_en, m_rate, m_pend, m_tog, m_req;
    logic [1:0]  m_idx;

    avi_pkt_sched u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .frame_start (frame_start),
        .send_req    (send_req),
        .send_idx    (send_idx),
        .send_word   (send_word),
        .send_done   (send_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL R8 watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        if (a < 3'd4) return m_cont[a[1:0]];
        if (a == 3'd4) return {29'd0, m_pend, m_rate, m_en};
        return 32'd0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_cont[i] = '0;
            m_shad[i] = '0;
        end
        m_en = 0; m_rate = 0; m_pend = 0; m_tog = 0; m_req = 0; m_idx = 0;
    endtask

    task automatic model_step(input bit fs, input bit dn, input bit wr,
                              input logic [2:0] a, input logic [31:0] d);
        logic [31:0] old_cont [4];
        logic old_en, old_rate, copy, fire;
        for (int i = 0; i < 4; i++) old_cont[i] = m_cont[i];
        old_en   = m_en;
        old_rate = m_rate;
        copy = fs && m_pend && !m_req;
        fire = fs && old_en && (!old_rate || !m_tog) && !m_req;
        if (wr && a < 3'd4) m_cont[a[1:0]] = d;
        if (wr && a == 3'd4) begin
            m_en   = d[0];
            m_rate = d[1];
        end
        m_pend = (m_pend && !copy) || (wr && a == 3'd4 && d[2]);
        if (copy) for (int i = 0; i < 4; i++) m_shad[i] = old_cont[i];
        if (!old_en || !old_rate) m_tog = 0;
        else if (fs) m_tog = ~m_tog;
        if (fire) begin
            m_req = 1; m_idx = 0;
        end else if (m_req && dn) begin
            if (m_idx == 2'd3) begin
                m_req = 0; m_idx = 0;
            end else begin
                m_idx = m_idx + 2'd1;
            end
        end
    endtask

    // one cycle: drive at negedge, check before posedge, advance model
    task automatic cyc(input string tag, input bit fs, input bit dn, input bit wr,
                       input logic [2:0] a, input logic [31:0] d);
        string tq, ti, tw, tr;
        tq = (tag == "") ? "R4" : tag;
        ti = (tag == "") ? "R8" : tag;
        tw = (tag == "") ? "R7" : tag;
        tr = (tag == "") ? "R2" : tag;
        frame_start = fs;
        send_done   = dn;
        reg_wr_en   = wr;
        reg_addr    = a;
        reg_wdata   = d;
        #1;
        chk(tq, "send_req", {31'd0, send_req}, {31'd0, m_req});
        if (m_req) begin
            chk(ti, "send_idx", {30'd0, send_idx}, {30'd0, m_idx});
            chk(tw, "send_word", send_word, m_shad[m_idx]);
        end
        chk(tr, "reg_rdata", reg_rdata, exp_rd(a));
        @(posedge clk);
        model_step(fs, dn, wr, a, d);
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 3'd4, 0);
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 4; i++) cyc(tag, 0, 1, 0, 3'd4, 0);
    endtask

    initial begin
        int unsigned seed;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) cyc("R1", 0, 0, 0, 3'(a), 0);

        // R2 register map and unused addresses
        for (int a = 0; a < 4; a++) cyc("R2", 0, 0, 1, 3'(a), 32'hA0B0C000 + 32'(a));
        cyc("R2", 0, 0, 1, 3'd5, 32'hFFFF_FFFF);
        cyc("R2", 0, 0, 1, 3'd7, 32'h1234_5678);
        for (int a = 0; a < 8; a++) cyc("R2", 0, 0, 0, 3'(a), 0);

        // R6 update staged, applied at frame start
        cyc("R6", 0, 0, 1, 3'd4, 32'h5);
        cyc("R6", 0, 0, 0, 3'd4, 0);
        cyc("R6", 0, 0, 1, 3'd4, 32'h1);
        cyc("R6", 1, 0, 0, 3'd4, 0);
        cyc("R6", 0, 0, 0, 3'd4, 0);

        // R8 ordered words with a held word
        cyc("R8", 0, 1, 0, 3'd4, 0);
        cyc("R8", 0, 0, 0, 3'd4, 0);
        cyc("R8", 0, 0, 0, 3'd4, 0);
        cyc("R8", 0, 1, 0, 3'd4, 0);
        cyc("R8", 0, 1, 0, 3'd4, 0);
        cyc("R8", 0, 1, 0, 3'd4, 0);
        idle("R8", 2);

        // R10 done while idle
        for (int i = 0; i < 3; i++) cyc("R10", 0, 1, 0, 3'd4, 0);

        // R7 content write without update
        cyc("R7", 0, 0, 1, 3'd0, 32'hDEAD_BEEF);
        cyc("R7", 1, 0, 0, 3'd0, 0);
        drain("R7");

        // R9 frame during a packet with update pending
        cyc("R9", 1, 0, 0, 3'd4, 0);
        cyc("R9", 0, 0, 1, 3'd4, 32'h5);
        cyc("R9", 1, 0, 0, 3'd4, 0);
        cyc("R9", 0, 1, 0, 3'd4, 0);
        drain("R9");
        cyc("R9", 1, 0, 0, 3'd4, 0);
        drain("R9");

        // R4 back-to-back frames each send
        for (int f = 0; f < 3; f++) begin
            cyc("R4", 1, 0, 0, 3'd4, 0);
            drain("R4");
        end

        // R3 disabled
        cyc("R3", 0, 0, 1, 3'd4, 32'h0);
        for (int f = 0; f < 3; f++) begin
            cyc("R3", 1, 0, 0, 3'd4, 0);
            idle("R3", 2);
        end

        // R5 every other frame
        cyc("R5", 0, 0, 1, 3'd4, 32'h3);
        for (int f = 0; f < 5; f++) begin
            cyc("R5", 1, 0, 0, 3'd4, 0);
            drain("R5");
        end
        cyc("R5", 0, 0, 1, 3'd4, 32'h1);
        cyc("R5", 0, 0, 1, 3'd4, 32'h3);
        cyc("R5", 1, 0, 0, 3'd4, 0);
        drain("R5");

        // random phase
        seed = $urandom(32'd7321);
        for (int i = 0; i < 5000; i++) begin
            bit fs, dn, wr;
            logic [2:0] a;
            logic [31:0] d;
            fs = ($urandom % 24) == 0;
            dn = ($urandom % 3) != 0;
            wr = ($urandom % 6) == 0;
            a  = 3'($urandom % 8);
            d  = $urandom;
            if (wr && a == 3'd4 && ($urandom % 4) != 0) d[0] = 1'b1;
            cyc("", fs, dn, wr, a, d);
        end

        summary();
        $finish;
    end
endmodule